// File: doc/BRIEF.md
# Inbound DMA Address Translator

This block sits on the inbound DMA path from a 32-bit peripheral bus into a wide system fabric. Each bus address falls into one of three regions. The low quarter is local and passes through untouched. The next gigabyte is page-mapped, one 4 KB page at a time, through an internal table of translation entries. The upper half is direct-mapped: the target is computed arithmetically from a programmable direct-map register. Each result carries a 48-bit target address, a target identifier, the entry attribute bits and an error flag.

Software programs the entry table and the direct-map register over a simple register port. An entry is written as one 64-bit word and read back as two 32-bit halves. Lookups enter through a valid/ready request channel. Each lookup leaves through a valid/ready result channel one cycle after it is accepted. The result register can stall under backpressure without losing data.

Top module: `dma_xlate`

## Requirements
- R1: After reset no result is pending, `req_ready` is 1, every table entry reads back as zero and the direct-map register reads back as zero.
- R2: A bus address below 0x4000_0000 is local. The result is the address zero-extended to 48 bits, with target identifier 0, attributes 0 and no error.
- R3: For a bus address from 0x4000_0000 to 0x7FFF_FFFF, the entry index is (address − 0x4000_0000) >> 12. If that entry has its valid bit set, the target is {entry[47:12], address[11:0]}, the target identifier is entry[11:8] and the attributes are entry[4:0]. The attribute bits are: bit 0 valid, bit 1 coherent, bit 2 precise, bit 3 prefetch, bit 4 barrier.
- R4: A page-mapped address whose entry index is 128 or more, or whose entry has bit 0 clear, sets the error flag. Target address, identifier and attributes are then all zero.
- R5: A bus address at or above 0x8000_0000 gives target = offset × 2^31 + address[30:0] + RAM_BASE, plus 0x2000_0000 when the add flag is set, modulo 2^48. The target identifier comes from the direct-map register and the attributes are 0. The direct-map register fields are: target identifier in [23:20], read-modify flag in [18], add flag in [17] and the 17-bit offset in [16:0].
- R6: A write stores a 64-bit entry. A read returns entry bits [31:0] (low half) or [63:32] (high half) on `cfg_rdata` one cycle after `cfg_rd_en`. A direct-map read returns the four fields in place, with all other bits zero. `cfg_rdata` holds its value between reads.
- R7: A request is accepted when `req_valid` and `req_ready` are both 1, and its result is valid on the next cycle. `req_ready` is 1 exactly when no result is pending or `rsp_ready` is 1. A pending result that is not taken stays unchanged.
- R8: A lookup accepted in the same cycle as a configuration write uses the table and direct-map contents from before the write. A read in that cycle also returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 48 | Translated target address |
| rsp_tid | output | 4 | Target identifier |
| rsp_attr | output | 5 | Entry attribute bits |
| rsp_err | output | 1 | Invalid-address error |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_dir | input | 1 | Write targets the direct-map register (else an entry) |
| cfg_wr_idx | input | 7 | Entry index of the write |
| cfg_wdata | input | 64 | Write data (direct-map register uses bits [31:0]) |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_rd_dir | input | 1 | Read the direct-map register (else an entry) |
| cfg_rd_hi | input | 1 | Entry read selects the upper 32-bit half |
| cfg_rd_idx | input | 7 | Entry index of the read |
| cfg_rdata | output | 32 | Read data, registered |

## Verification
The bench targets these corner cases:
- Region edges at 0x3FFF_FFFF, 0x4000_0000, 0x7FFF_FFFF and 0x8000_0000. A misdecoded top bit sends an address down the wrong path.
- Entry indices 127 and 128. An off-by-one bound check either translates through a nonexistent entry or faults on the last real one.
- Offset 0x1FFFF combined with the add flag. This forces the direct-path sum to wrap at 48 bits, which catches a narrowed adder or a dropped base term.
- Long stalls on `rsp_ready`, and a table write that coincides with a lookup of the same entry. A design that overwrote a held result, or that forwarded the new entry, would show a changed result.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

    typedef enum logic [1:0] {
        REG_LOCAL  = 2'd0,
        REG_PAGED  = 2'd1,
        REG_DIRECT = 2'd2
    } region_e;

    // Entry attribute bit positions (decoded by fabric-side logic)
    localparam int ATTR_VALID = 0;
    localparam int ENT_TID_LSB = 8;

    // Direct-map register content; field positions are fixed by software
    typedef struct packed {
        logic [3:0]  tid;
        logic        rmf;
        logic        add512;
        logic [16:0] off;
    } dirmap_t;

endpackage

// File: rtl/dxl_region_dec.sv
module dxl_region_dec
    import dxl_pkg::*;
#(
    parameter int BUS_AW     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 7
) (
    input  logic [BUS_AW-1:PAGE_SHIFT] page,
    output region_e                    region,
    output logic [IDX_W-1:0]           idx,
    output logic                       idx_oob
);
    // Pages inside the 1 GB mapped window
    localparam int WIN_BITS = BUS_AW - 2 - PAGE_SHIFT;

    always_comb begin
        if (page[BUS_AW-1])      region = REG_DIRECT;
        else if (page[BUS_AW-2]) region = REG_PAGED;
        else                     region = REG_LOCAL;
    end

    assign idx = page[PAGE_SHIFT +: IDX_W];

    generate
        if (WIN_BITS > IDX_W) begin : g_bound
            assign idx_oob = |page[BUS_AW-3 : PAGE_SHIFT+IDX_W];
        end else begin : g_nobound
            assign idx_oob = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/dxl_entry_table.sv
module dxl_entry_table
    import dxl_pkg::*;
#(
    parameter int ENTRIES    = 128,
    parameter int ENT_W      = 64,
    parameter int SYS_AW     = 48,
    parameter int PAGE_SHIFT = 12,
    parameter int TID_W      = 4,
    parameter int ATTR_W     = 5,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [ENT_W-1:0]             wr_data,
    input  logic [IDX_W-1:0]             lk_idx,
    output logic [SYS_AW-PAGE_SHIFT-1:0] lk_pfn,
    output logic [TID_W-1:0]             lk_tid,
    output logic [ATTR_W-1:0]            lk_attr,
    input  logic [IDX_W-1:0]             rd_idx,
    output logic [ENT_W-1:0]             rd_entry
);
    logic [ENT_W-1:0] ent_q [ENTRIES];
    logic [ENT_W-1:0] ent_d [ENTRIES];

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
            always_comb begin
                ent_d[g] = ent_q[g];
                if (wr_en && (wr_idx == IDX_W'(g))) ent_d[g] = wr_data;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ent_q[g] <= '0;
                else        ent_q[g] <= ent_d[g];
            end
        end
    endgenerate

    logic [ENT_W-1:0] lk_entry;
    assign lk_entry = ent_q[lk_idx];
    assign lk_pfn   = lk_entry[SYS_AW-1:PAGE_SHIFT];
    assign lk_tid   = lk_entry[ENT_TID_LSB +: TID_W];
    assign lk_attr  = lk_entry[ATTR_W-1:0];
    assign rd_entry = ent_q[rd_idx];

endmodule

// File: rtl/dxl_direct_calc.sv
module dxl_direct_calc #(
    parameter int              BUS_AW   = 32,
    parameter int              SYS_AW   = 48,
    parameter int              OFF_W    = 17,
    parameter logic [47:0]     RAM_BASE = 48'h0000_1000_0000
) (
    input  logic [OFF_W-1:0]  off,
    input  logic              add512,
    input  logic [BUS_AW-2:0] low,
    output logic [SYS_AW-1:0] tgt
);
    // The offset's lsb lines up with target bit BUS_AW-1 (2 GB steps)
    localparam int              SEG_SHIFT = BUS_AW - 1;
    localparam logic [SYS_AW-1:0] STEP_512M = SYS_AW'(64'h2000_0000);
    localparam logic [SYS_AW-1:0] BASE_C    = SYS_AW'(RAM_BASE);

    logic [SYS_AW-1:0] seg;
    assign seg = SYS_AW'(off) << SEG_SHIFT;
    assign tgt = seg + SYS_AW'(low) + BASE_C + (add512 ? STEP_512M : '0);

endmodule

// File: rtl/dma_xlate.sv
module dma_xlate
    import dxl_pkg::*;
#(
    parameter int          BUS_AW     = 32,
    parameter int          SYS_AW     = 48,
    parameter int          ENTRIES    = 128,
    parameter int          PAGE_SHIFT = 12,
    parameter int          TID_W      = 4,
    parameter int          ATTR_W     = 5,
    parameter int          ENT_W      = 64,
    parameter logic [47:0] RAM_BASE   = 48'h0000_1000_0000,
    localparam int         IDX_W      = $clog2(ENTRIES),
    localparam int         HALF_W     = ENT_W / 2,
    localparam int         OFF_W      = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BUS_AW-1:0] req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [SYS_AW-1:0] rsp_addr,
    output logic [TID_W-1:0]  rsp_tid,
    output logic [ATTR_W-1:0] rsp_attr,
    output logic              rsp_err,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_dir,
    input  logic [IDX_W-1:0]  cfg_wr_idx,
    input  logic [ENT_W-1:0]  cfg_wdata,
    input  logic              cfg_rd_en,
    input  logic              cfg_rd_dir,
    input  logic              cfg_rd_hi,
    input  logic [IDX_W-1:0]  cfg_rd_idx,
    output logic [HALF_W-1:0] cfg_rdata
);
    typedef struct packed {
        logic              valid;
        logic              err;
        logic [SYS_AW-1:0] addr;
        logic [TID_W-1:0]  tid;
        logic [ATTR_W-1:0] attr;
        dirmap_t           dir;
        logic [HALF_W-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    region_e                    region;
    logic [IDX_W-1:0]           lk_idx;
    logic                       idx_oob;
    logic [SYS_AW-PAGE_SHIFT-1:0] lk_pfn;
    logic [TID_W-1:0]           lk_tid;
    logic [ATTR_W-1:0]          lk_attr;
    logic [ENT_W-1:0]           rd_entry;
    logic [SYS_AW-1:0]          dir_tgt;
    logic                       accept;

    dxl_region_dec #(
        .BUS_AW(BUS_AW), .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(IDX_W)
    ) u_dec (
        .page(req_addr[BUS_AW-1:PAGE_SHIFT]),
        .region(region),
        .idx(lk_idx),
        .idx_oob(idx_oob)
    );

    dxl_entry_table #(
        .ENTRIES(ENTRIES), .ENT_W(ENT_W), .SYS_AW(SYS_AW),
        .PAGE_SHIFT(PAGE_SHIFT), .TID_W(TID_W), .ATTR_W(ATTR_W)
    ) u_tab (
        .clk(clk),
        .rst_n(rst_n),
        .wr_en(cfg_wr_en && !cfg_wr_dir),
        .wr_idx(cfg_wr_idx),
        .wr_data(cfg_wdata),
        .lk_idx(lk_idx),
        .lk_pfn(lk_pfn),
        .lk_tid(lk_tid),
        .lk_attr(lk_attr),
        .rd_idx(cfg_rd_idx),
        .rd_entry(rd_entry)
    );

    dxl_direct_calc #(
        .BUS_AW(BUS_AW), .SYS_AW(SYS_AW), .OFF_W(OFF_W), .RAM_BASE(RAM_BASE)
    ) u_dir (
        .off(st_q.dir.off),
        .add512(st_q.dir.add512),
        .low(req_addr[BUS_AW-2:0]),
        .tgt(dir_tgt)
    );

    assign req_ready = !st_q.valid || rsp_ready;
    assign accept    = req_valid && req_ready;

    always_comb begin
        st_d = st_q;

        // result channel: drop the pending result once taken
        if (rsp_ready) st_d.valid = 1'b0;

        if (accept) begin
            st_d.valid = 1'b1;
            st_d.err   = 1'b0;
            st_d.addr  = '0;
            st_d.tid   = '0;
            st_d.attr  = '0;
            unique case (region)
                REG_LOCAL: begin
                    st_d.addr = SYS_AW'(req_addr);
                end
                REG_PAGED: begin
                    if (idx_oob || !lk_attr[ATTR_VALID]) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.addr = {lk_pfn, req_addr[PAGE_SHIFT-1:0]};
                        st_d.tid  = lk_tid;
                        st_d.attr = lk_attr;
                    end
                end
                REG_DIRECT: begin
                    st_d.addr = dir_tgt;
                    st_d.tid  = TID_W'(st_q.dir.tid);
                end
                default: begin
                    st_d.err = 1'b1;
                end
            endcase
        end

        // register port
        if (cfg_rd_en) begin
            if (cfg_rd_dir)
                st_d.rdata = HALF_W'({st_q.dir.tid, 1'b0, st_q.dir.rmf,
                                      st_q.dir.add512, st_q.dir.off});
            else if (cfg_rd_hi)
                st_d.rdata = rd_entry[ENT_W-1:HALF_W];
            else
                st_d.rdata = rd_entry[HALF_W-1:0];
        end

        if (cfg_wr_en && cfg_wr_dir) begin
            st_d.dir.tid    = cfg_wdata[23:20];
            st_d.dir.rmf    = cfg_wdata[18];
            st_d.dir.add512 = cfg_wdata[17];
            st_d.dir.off    = cfg_wdata[OFF_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.valid;
    assign rsp_addr  = st_q.addr;
    assign rsp_tid   = st_q.tid;
    assign rsp_attr  = st_q.attr;
    assign rsp_err   = st_q.err;
    assign cfg_rdata = st_q.rdata;

endmodule

// File: rtl/dxl_checker.sv
module dxl_checker #(
    parameter int BUS_AW = 32,
    parameter int SYS_AW = 48,
    parameter int TID_W  = 4,
    parameter int ATTR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [BUS_AW-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [SYS_AW-1:0] rsp_addr,
    input logic [TID_W-1:0]  rsp_tid,
    input logic [ATTR_W-1:0] rsp_attr,
    input logic              rsp_err,
    input logic              cfg_rd_en,
    input logic              cfg_rd_dir,
    input logic [31:0]       cfg_rdata
);
    logic acc;
    assign acc = req_valid && req_ready;

    // R7: accepted request yields a result on the next cycle
    a_r7_accept_to_result: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    // R7: a stalled result stays put
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) &&
            $stable(rsp_tid) && $stable(rsp_attr) && $stable(rsp_err)));

    // R2: local addresses pass through unchanged
    a_r2_local_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_addr[BUS_AW-1] && !req_addr[BUS_AW-2]) |=>
            (rsp_addr == SYS_AW'($past(req_addr)) && !rsp_err && rsp_tid == '0));

    // R4: index beyond the table raises the error
    a_r4_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_addr[31] && req_addr[30] && (|req_addr[29:19])) |=> rsp_err);

    // R4: an error result carries no translation
    a_r4_err_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_addr == '0 && rsp_tid == '0 && rsp_attr == '0));

    // R3: nonzero attributes only come from a valid entry
    a_r3_attr_from_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && rsp_attr != '0) |-> rsp_attr[0]);

    // R6: direct-map readback has no bits above the identifier field
    a_r6_dir_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_en && cfg_rd_dir) |=> (cfg_rdata[31:24] == 8'h00));

endmodule

bind dma_xlate dxl_checker #(
    .BUS_AW(BUS_AW), .SYS_AW(SYS_AW), .TID_W(TID_W), .ATTR_W(ATTR_W)
) u_chk (.*);

// File: tb/dma_xlate_tb_top.sv
module dma_xlate_tb_top;
    localparam logic [47:0] BASE = 48'h0000_1000_0000;
    localparam logic [63:0] M48  = 64'h0000_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, rsp_ready = 1;
    logic [31:0] req_addr = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [47:0] rsp_addr;
    logic [3:0]  rsp_tid;
    logic [4:0]  rsp_attr;
    logic        cfg_wr_en = 0, cfg_wr_dir = 0, cfg_rd_en = 0, cfg_rd_dir = 0, cfg_rd_hi = 0;
    logic [6:0]  cfg_wr_idx = '0, cfg_rd_idx = '0;
    logic [63:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;

    always #2 clk = ~clk;

    dma_xlate #(.RAM_BASE(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
        .rsp_tid(rsp_tid), .rsp_attr(rsp_attr), .rsp_err(rsp_err),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_dir(cfg_wr_dir), .cfg_wr_idx(cfg_wr_idx),
        .cfg_wdata(cfg_wdata), .cfg_rd_en(cfg_rd_en), .cfg_rd_dir(cfg_rd_dir),
        .cfg_rd_hi(cfg_rd_hi), .cfg_rd_idx(cfg_rd_idx), .cfg_rdata(cfg_rdata)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [63:0] tab [128];
    logic [31:0] dirw;
    bit          m_valid;
    logic [63:0] m_addr;
    int          m_tid, m_attr;
    bit          m_err;
    string       m_tag;
    logic [31:0] m_rdata;
    bit          m_acc;
    int          m_idx;

    task automatic xlate(input logic [31:0] a, output logic [63:0] t, output int tid,
                         output int attr, output bit err, output string tag, output int idx);
        t = 0; tid = 0; attr = 0; err = 0; idx = -1;
        if (a < 32'h4000_0000) begin
            t = {32'h0, a}; tag = "R2";
        end else if (a < 32'h8000_0000) begin
            idx = int'((a - 32'h4000_0000) >> 12);
            if (idx >= 128 || tab[idx][0] == 1'b0) begin
                err = 1; tag = "R4";
            end else begin
                t    = (tab[idx] & 64'h0000_FFFF_FFFF_F000) | {52'h0, a[11:0]};
                tid  = int'(tab[idx][11:8]);
                attr = int'(tab[idx][4:0]);
                tag  = "R3";
            end
        end else begin
            t = {47'h0, dirw[16:0]} * 64'h8000_0000 + {33'h0, a[30:0]} + {16'h0, BASE};
            if (dirw[17]) t = t + 64'h2000_0000;
            t   = t & M48;
            tid = int'(dirw[23:20]);
            tag = "R5";
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (tab[i]) tab[i] = '0;
            dirw = '0; m_valid = 0; m_rdata = '0;
        end else begin
            m_acc = req_valid && (!m_valid || rsp_ready);
            if (cfg_rd_en)
                m_rdata = cfg_rd_dir ? dirw : (cfg_rd_hi ? tab[cfg_rd_idx][63:32]
                                                         : tab[cfg_rd_idx][31:0]);
            if (m_acc) begin
                xlate(req_addr, m_addr, m_tid, m_attr, m_err, m_tag, m_idx);
                m_valid = 1;
                // R8: same-cycle write to the entry being looked up
                if (cfg_wr_en && !cfg_wr_dir && m_idx == int'(cfg_wr_idx)) m_tag = "R8";
                if (cfg_wr_en && cfg_wr_dir && m_tag == "R5") m_tag = "R8";
            end else if (rsp_ready) begin
                m_valid = 0;
            end
            if (cfg_wr_en) begin
                if (cfg_wr_dir) dirw = cfg_wdata[31:0] & 32'h00F7_FFFF;
                else            tab[cfg_wr_idx] = cfg_wdata;
            end
        end
    end

    // compare on every clock, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            chk("R1", {63'h0, rsp_valid}, 64'h0);
            chk("R1", {63'h0, req_ready}, 64'h1);
        end else if (!done) begin
            chk("R7", {63'h0, rsp_valid}, {63'h0, m_valid});
            chk("R7", {63'h0, req_ready}, {63'h0, (!m_valid || rsp_ready)});
            if (m_valid) begin
                chk(m_tag, {16'h0, rsp_addr}, m_addr);
                chk(m_tag, {60'h0, rsp_tid}, 64'(m_tid));
                chk(m_tag, {59'h0, rsp_attr}, 64'(m_attr));
                chk(m_tag, {63'h0, rsp_err}, {63'h0, m_err});
            end
            chk("R6", {32'h0, cfg_rdata}, {32'h0, m_rdata});
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr_ent(input int idx, input logic [63:0] v);
        @(negedge clk);
        cfg_wr_en = 1; cfg_wr_dir = 0; cfg_wr_idx = 7'(idx); cfg_wdata = v;
        @(negedge clk);
        cfg_wr_en = 0;
    endtask

    task automatic wr_dir(input logic [31:0] v);
        @(negedge clk);
        cfg_wr_en = 1; cfg_wr_dir = 1; cfg_wdata = {32'h0, v};
        @(negedge clk);
        cfg_wr_en = 0;
    endtask

    task automatic rd(input bit d, input bit hi, input int idx);
        @(negedge clk);
        cfg_rd_en = 1; cfg_rd_dir = d; cfg_rd_hi = hi; cfg_rd_idx = 7'(idx);
        @(negedge clk);
        cfg_rd_en = 0;
    endtask

    task automatic look(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1; req_addr = a; rsp_ready = 1;
        @(negedge clk);
        req_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: table and direct-map register read back as zero
        rd(0, 0, 5); chk("R1", {32'h0, cfg_rdata}, 64'h0);
        rd(0, 1, 127); chk("R1", {32'h0, cfg_rdata}, 64'h0);
        rd(1, 0, 0); chk("R1", {32'h0, cfg_rdata}, 64'h0);

        // R2 local, incl. the top edge of the region
        look(32'h0000_0000); look(32'h1234_5678); look(32'h3FFF_FFFF);
        // R4 before programming
        look(32'h4000_0000);

        wr_ent(0,   64'hABCD_0012_3456_7A19);
        wr_ent(5,   64'h0000_0987_6543_2C1F);
        wr_ent(127, 64'h0000_FFFF_FFFF_F305);
        wr_ent(9,   64'h0000_0000_5555_5F1E);   // bit 0 clear
        look(32'h4000_0ABC); look(32'h4000_5FFF); look(32'h4007_F123);
        look(32'h4008_0000); look(32'h7FFF_FFFF); look(32'h4000_9000);

        // R5 direct path
        look(32'h8000_0000); look(32'hFFFF_FFFF);
        wr_dir(32'hFF5_2345);
        look(32'h8000_0010); look(32'hC000_1234);
        wr_dir(32'h0073_FFFF);                     // offset all ones + add flag
        look(32'hFFFF_FFFF); look(32'h8765_4321);

        // R6 readback
        rd(0, 0, 0); rd(0, 1, 0); rd(0, 1, 127); rd(1, 0, 0);

        // R8 same-cycle write and lookup
        @(negedge clk);
        req_valid = 1; req_addr = 32'h4000_5004;
        cfg_wr_en = 1; cfg_wr_dir = 0; cfg_wr_idx = 7'd5; cfg_wdata = 64'h0000_0000_1111_1000;
        @(negedge clk);
        req_valid = 1; req_addr = 32'h4000_5004; cfg_wr_en = 0;
        @(negedge clk);
        req_valid = 1; req_addr = 32'h9000_0000;
        cfg_wr_en = 1; cfg_wr_dir = 1; cfg_wdata = 64'h0000_0000_0020_0001;
        @(negedge clk);
        req_valid = 0; cfg_wr_en = 0;

        // R7 backpressure: hold rsp_ready low with a request waiting
        @(negedge clk);
        req_valid = 1; req_addr = 32'h0000_1000;
        @(negedge clk);
        rsp_ready = 0; req_addr = 32'h0000_2000;
        repeat (4) @(negedge clk);
        rsp_ready = 1;
        @(negedge clk);
        req_valid = 0;

        // mixed traffic
        void'($urandom(32'd7));
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            req_valid = ($urandom % 4) != 0;
            rsp_ready = ($urandom % 3) != 0;
            case ($urandom % 4)
                0:       req_addr = $urandom & 32'h3FFF_FFFF;
                1, 2:    req_addr = 32'h4000_0000 | (($urandom % 160) << 12) | ($urandom & 32'hFFF);
                default: req_addr = 32'h8000_0000 | $urandom;
            endcase
            cfg_wr_en  = ($urandom % 12) == 0;
            cfg_wr_dir = ($urandom % 5) == 0;
            cfg_wr_idx = 7'($urandom);
            cfg_wdata  = {$urandom, $urandom};
            cfg_rd_en  = ($urandom % 4) == 0;
            cfg_rd_dir = ($urandom % 4) == 0;
            cfg_rd_hi  = 1'($urandom);
            cfg_rd_idx = 7'($urandom);
        end
        @(negedge clk);
        req_valid = 0; cfg_wr_en = 0; cfg_rd_en = 0; rsp_ready = 1;
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule